// File: doc/BRIEF.md
# TDM Time-Slot Channel Assigner

This block sits between a serial TDM frame of 32 eight-bit slots and a bank of 32 logical HDLC channels. A slot table holds one 16-bit entry per slot. The entry names the logical channel that owns the slot and marks which of the slot's eight bit positions carry data. It also holds three control flags: half-rate operation, path selection and contention-bus gating. Each cycle the block reads the entry for the current bit position and presents the result on its outputs. These are a receive-sample enable, a transmit-drive enable, a transmit-advance strobe, the owning channel number, the selected receive bit, the direct output bit, and the contention-bus controls.

A host loads the table through two registers. The address register selects a slot and carries a start/stop flag for a fill sequencer. The data register holds an entry value, which a separate commit strobe stores into the selected slot. The fill sequencer runs after every reset. It stamps the data register contents into one slot per cycle, replacing the channel field with the slot's own index, and keeps cycling until the host stops it.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset, `initBusy` is 1, the data register and every table entry are zero, and `txEn`, `rxEn` and `txAdvance` stay 0 until the first `frameSync`.
- R2: The entry layout is: bits [4:0] channel, bits [12:5] per-bit valid mask (bit 5 = first bit of the slot, bit 12 = last), bit 13 half-rate, bit 14 direct path, bit 15 contention enable. `rdData` shows the entry at the address register. `memWr` while idle stores the data register into that entry.
- R3: `memWr` while `initBusy` is 1 leaves the table unchanged.
- R4: `addrIn` bits [4:0] give the slot and bit 5 gives the fill flag. Writing the flag as 1 starts the fill at slot 0. While busy, each cycle writes {data[15:5], slot index} to the next slot in ascending order, wrapping. Writing the flag as 0 stops the fill on the next edge.
- R5: A `frameSync` cycle makes the next cycle bit 0 of slot 0. The bit position advances every cycle, the slot advances every 8 bits, and the frame wraps after slot 31 bit 7.
- R6: `chanId` is the current slot's channel field. `txEn` is 1 exactly when the block is synchronised and the current bit's valid flag is 1.
- R7: With half-rate at 0, `rxEn` and `txAdvance` equal `txEn` in every frame.
- R8: With half-rate at 1, `rxEn` and `txAdvance` follow `txEn` in the first frame of each pair and are 0 in the second. `txEn` still marks the bits in the second frame, so the same transmit bits are repeated. The frame after the first `frameSync` is a first frame, and every frame start after that toggles the pair phase.
- R9: With direct path at 1, `rxData` = `directIn` and `directOut` = `txData`. With it at 0, `rxData` = `matrixOut7` and `directOut` = `matrixOut6`.
- R10: With `contentionMode` at 0, `echoMask` equals the contention-enable bit. With `contentionMode` at 1, `echoMask` is 0. `cbPullLow` is 1 when (`contentionMode` or contention enable) and `txEn` and `txData` is 0. Otherwise the open-drain line is released.
- R11: `swReset` clears the data register and restarts the fill at slot 0, with `initBusy` at 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low reset |
| swReset | input | 1 | Software reset strobe |
| frameSync | input | 1 | Frame start marker; the next cycle is slot 0 bit 0 |
| addrWr | input | 1 | Address register write strobe |
| addrIn | input | 6 | Slot index [4:0] and fill flag [5] |
| dataWr | input | 1 | Data register write strobe |
| dataIn | input | 16 | Data register value |
| memWr | input | 1 | Commit data register to the addressed slot |
| rdData | output | 16 | Entry at the address register |
| initBusy | output | 1 | Fill sequencer running |
| contentionMode | input | 1 | Contention mode on |
| txData | input | 1 | Transmit controller bit |
| directIn | input | 1 | Direct receive pin |
| matrixOut6 | input | 1 | Switching matrix output 6 |
| matrixOut7 | input | 1 | Switching matrix output 7 |
| chanId | output | 5 | Channel owning the current slot |
| txEn | output | 1 | Transmit-drive enable for this bit |
| rxEn | output | 1 | Receive-sample enable for this bit |
| txAdvance | output | 1 | Transmit controller consumes a new bit |
| rxData | output | 1 | Selected receive bit |
| directOut | output | 1 | Direct output pin |
| cbPullLow | output | 1 | Pull the open-drain contention line low |
| echoMask | output | 1 | Disregard the echo input |

## Verification
The slot outputs are combinational from the registered bit position and table. They therefore change in the cycle after the edge that consumes `frameSync` or advances the counters. A host commit or fill write appears on `rdData` in the cycle after its edge. The pair phase changes on the edge that starts a frame. The bench reference model updates on each rising edge from the inputs held since the previous falling edge. Every output is compared a quarter period after that edge, so each result is checked in the first cycle it is due. Frame-level totals of enable cycles cover the half-rate repeat and discard behaviour.

// File: rtl/slotasg_pkg.sv
package slotasg_pkg;
  localparam int SLOTS   = 32;
  localparam int BITS    = 8;
  localparam int CHW     = $clog2(SLOTS);
  localparam int BW      = $clog2(BITS);
  localparam int ENTRY_W = 3 + BITS + CHW;

  typedef struct packed {
    logic            cbEnable;
    logic            directPath;
    logic            halfRate;
    logic [BITS-1:0] valid;
    logic [CHW-1:0]  chan;
  } slotEntry_t;

  typedef struct packed {
    logic           fillWe;
    logic           hostWe;
    logic           clearData;
    logic [CHW-1:0] fillIdx;
    logic [CHW-1:0] hostAddr;
    logic [CHW-1:0] slot;
    logic [BW-1:0]  bitIdx;
    logic           secondFrame;
    logic           synced;
  } ctlStrobes_t;
endpackage

// File: rtl/slotasg_ctrl.sv
module slotasg_ctrl
  import slotasg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          swReset,
  input  logic          frameSync,
  input  logic          addrWr,
  input  logic [CHW:0]  addrIn,
  input  logic          memWr,
  output ctlStrobes_t   ctl,
  output logic          initBusy
);
  localparam logic [CHW-1:0] LAST_SLOT = CHW'(SLOTS - 1);
  localparam logic [BW-1:0]  LAST_BIT  = BW'(BITS - 1);

  logic [CHW-1:0] addrQ, idxQ, slotQ;
  logic [BW-1:0]  bitQ;
  logic           busyQ, secondQ, syncedQ;

  // host side: address register and fill sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else begin
      if (addrWr) addrQ <= addrIn[CHW-1:0];
      if (swReset) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
      end else if (addrWr) begin
        busyQ <= addrIn[CHW];
        idxQ  <= '0;
      end else if (busyQ) begin
        idxQ <= (idxQ == LAST_SLOT) ? '0 : idxQ + 1'b1;
      end
    end
  end

  // line side: bit and slot position, pair phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ   <= '0;
      bitQ    <= '0;
      secondQ <= 1'b0;
      syncedQ <= 1'b0;
    end else if (frameSync) begin
      slotQ   <= '0;
      bitQ    <= '0;
      secondQ <= syncedQ & ~secondQ;
      syncedQ <= 1'b1;
    end else if (syncedQ) begin
      if (bitQ == LAST_BIT) begin
        bitQ <= '0;
        if (slotQ == LAST_SLOT) begin
          slotQ   <= '0;
          secondQ <= ~secondQ;
        end else begin
          slotQ <= slotQ + 1'b1;
        end
      end else begin
        bitQ <= bitQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.fillWe      = busyQ;
    ctl.hostWe      = memWr & ~busyQ;
    ctl.clearData   = swReset;
    ctl.fillIdx     = idxQ;
    ctl.hostAddr    = addrQ;
    ctl.slot        = slotQ;
    ctl.bitIdx      = bitQ;
    ctl.secondFrame = secondQ;
    ctl.synced      = syncedQ;
  end

  assign initBusy = busyQ;
endmodule

// File: rtl/slotasg_dp.sv
module slotasg_dp
  import slotasg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               dataWr,
  input  logic [ENTRY_W-1:0] dataIn,
  input  logic               contentionMode,
  input  logic               txData,
  input  logic               directIn,
  input  logic               matrixOut6,
  input  logic               matrixOut7,
  output logic [ENTRY_W-1:0] rdData,
  output logic [CHW-1:0]     chanId,
  output logic               txEn,
  output logic               rxEn,
  output logic               txAdvance,
  output logic               rxData,
  output logic               directOut,
  output logic               cbPullLow,
  output logic               echoMask
);
  slotEntry_t dataQ;
  slotEntry_t table_q [SLOTS];
  slotEntry_t fillEntry, cur;
  logic       bitOn, takeNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (ctl.clearData) dataQ <= '0;
    else if (dataWr)        dataQ <= slotEntry_t'(dataIn);
  end

  always_comb begin
    fillEntry      = dataQ;
    fillEntry.chan = ctl.fillIdx;
  end

  // one row per slot; the fill sequencer has priority over a host commit
  for (genvar r = 0; r < SLOTS; r++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        table_q[r] <= '0;
      else if (ctl.fillWe && ctl.fillIdx == CHW'(r))
        table_q[r] <= fillEntry;
      else if (ctl.hostWe && ctl.hostAddr == CHW'(r))
        table_q[r] <= dataQ;
    end
  end

  assign rdData = table_q[ctl.hostAddr];
  assign cur    = table_q[ctl.slot];

  always_comb begin
    bitOn     = ctl.synced & cur.valid[ctl.bitIdx];
    takeNew   = ~cur.halfRate | ~ctl.secondFrame;
    txEn      = bitOn;
    rxEn      = bitOn & takeNew;
    txAdvance = bitOn & takeNew;
    chanId    = cur.chan;
    rxData    = cur.directPath ? directIn : matrixOut7;
    directOut = cur.directPath ? txData   : matrixOut6;
    echoMask  = ~contentionMode & cur.cbEnable;
    cbPullLow = (contentionMode | cur.cbEnable) & bitOn & ~txData;
  end
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import slotasg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               swReset,
  input  logic               frameSync,
  input  logic               addrWr,
  input  logic [CHW:0]       addrIn,
  input  logic               dataWr,
  input  logic [ENTRY_W-1:0] dataIn,
  input  logic               memWr,
  output logic [ENTRY_W-1:0] rdData,
  output logic               initBusy,
  input  logic               contentionMode,
  input  logic               txData,
  input  logic               directIn,
  input  logic               matrixOut6,
  input  logic               matrixOut7,
  output logic [CHW-1:0]     chanId,
  output logic               txEn,
  output logic               rxEn,
  output logic               txAdvance,
  output logic               rxData,
  output logic               directOut,
  output logic               cbPullLow,
  output logic               echoMask
);
  ctlStrobes_t ctl;

  slotasg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .swReset(swReset), .frameSync(frameSync),
    .addrWr(addrWr), .addrIn(addrIn), .memWr(memWr),
    .ctl(ctl), .initBusy(initBusy)
  );

  slotasg_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataWr(dataWr), .dataIn(dataIn),
    .contentionMode(contentionMode), .txData(txData), .directIn(directIn),
    .matrixOut6(matrixOut6), .matrixOut7(matrixOut7),
    .rdData(rdData), .chanId(chanId), .txEn(txEn), .rxEn(rxEn),
    .txAdvance(txAdvance), .rxData(rxData), .directOut(directOut),
    .cbPullLow(cbPullLow), .echoMask(echoMask)
  );
endmodule

// File: rtl/slotasg_chk.sv
module slotasg_chk
  import slotasg_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         swReset,
  input logic         frameSync,
  input logic         addrWr,
  input logic [CHW:0] addrIn,
  input logic         contentionMode,
  input ctlStrobes_t  ctl,
  input logic         initBusy,
  input logic         txEn,
  input logic         rxEn,
  input logic         txAdvance,
  input logic         echoMask
);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  p_quiet_unsynced_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.synced |-> !txEn);

  p_fill_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addrWr && !addrIn[CHW] && !swReset) |=> !initBusy);

  p_sync_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (ctl.slot == '0 && ctl.bitIdx == '0));

  p_bit_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.synced && !frameSync && ctl.bitIdx != LAST_BIT)
      |=> ctl.bitIdx == $past(ctl.bitIdx) + 1'b1);

  p_rx_within_tx_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxEn |-> txEn);

  p_adv_within_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    txAdvance |-> txEn);

  p_first_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !ctl.synced) |=> !ctl.secondFrame);

  p_echo_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    contentionMode |-> !echoMask);

  p_swreset_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> initBusy);
endmodule

bind tdm_slot_assigner slotasg_chk chk_i (
  .clk(clk), .rstN(rstN), .swReset(swReset), .frameSync(frameSync),
  .addrWr(addrWr), .addrIn(addrIn), .contentionMode(contentionMode),
  .ctl(ctl), .initBusy(initBusy), .txEn(txEn), .rxEn(rxEn),
  .txAdvance(txAdvance), .echoMask(echoMask)
);

// File: tb/tdm_slot_assigner_tb_top.sv
module tdm_slot_assigner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rstN = 1'b0, swReset = 1'b0, frameSync = 1'b0, addrWr = 1'b0;
  logic [5:0] addrIn = '0;
  logic dataWr = 1'b0, memWr = 1'b0;
  logic [15:0] dataIn = '0;
  logic contentionMode = 1'b0, txData = 1'b0, directIn = 1'b0;
  logic matrixOut6 = 1'b0, matrixOut7 = 1'b0;
  logic [15:0] rdData;
  logic [4:0] chanId;
  logic initBusy, txEn, rxEn, txAdvance, rxData, directOut, cbPullLow, echoMask;

  tdm_slot_assigner dut_i (
    .clk(clk), .rstN(rstN), .swReset(swReset), .frameSync(frameSync),
    .addrWr(addrWr), .addrIn(addrIn), .dataWr(dataWr), .dataIn(dataIn),
    .memWr(memWr), .rdData(rdData), .initBusy(initBusy),
    .contentionMode(contentionMode), .txData(txData), .directIn(directIn),
    .matrixOut6(matrixOut6), .matrixOut7(matrixOut7), .chanId(chanId),
    .txEn(txEn), .rxEn(rxEn), .txAdvance(txAdvance), .rxData(rxData),
    .directOut(directOut), .cbPullLow(cbPullLow), .echoMask(echoMask)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] mMem [32];
  logic [15:0] mData;
  int mAddr, mIdx, mSlot, mBit;
  bit mBusy, mSecond, mSynced;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mMem[i] = '0;
      mData = '0; mAddr = 0; mIdx = 0; mSlot = 0; mBit = 0;
      mBusy = 1'b1; mSecond = 1'b0; mSynced = 1'b0;
    end else begin
      if (mBusy) mMem[mIdx] = {mData[15:5], 5'(mIdx)};
      else if (memWr) mMem[mAddr] = mData;
      if (swReset) mData = '0;
      else if (dataWr) mData = dataIn;
      if (swReset) begin
        mBusy = 1'b1; mIdx = 0;
      end else if (addrWr) begin
        mBusy = addrIn[5]; mIdx = 0;
      end else if (mBusy) begin
        mIdx = (mIdx + 1) % 32;
      end
      if (addrWr) mAddr = int'(addrIn[4:0]);
      if (frameSync) begin
        mSecond = mSynced ? !mSecond : 1'b0;
        mSynced = 1'b1; mSlot = 0; mBit = 0;
      end else if (mSynced) begin
        mBit++;
        if (mBit == 8) begin
          mBit = 0; mSlot++;
          if (mSlot == 32) begin
            mSlot = 0; mSecond = !mSecond;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #(QTR);
      if (rstN && !done) begin
        logic [15:0] e;
        bit vb, take;
        e = mMem[mSlot];
        vb = mSynced && e[5 + mBit];
        take = !e[13] || !mSecond;
        chk("R5/R6", "chanId", int'(chanId), int'(e[4:0]));
        chk("R6", "txEn", int'(txEn), int'(vb));
        chk("R7/R8", "rxEn", int'(rxEn), int'(vb && take));
        chk("R7/R8", "txAdvance", int'(txAdvance), int'(vb && take));
        chk("R9", "rxData", int'(rxData), int'(e[14] ? directIn : matrixOut7));
        chk("R9", "directOut", int'(directOut), int'(e[14] ? txData : matrixOut6));
        chk("R10", "echoMask", int'(echoMask), int'(!contentionMode && e[15]));
        chk("R10", "cbPullLow", int'(cbPullLow),
            int'((contentionMode || e[15]) && vb && !txData));
        chk("R2", "rdData", int'(rdData), int'(mMem[mAddr]));
        chk("R4", "initBusy", int'(initBusy), int'(mBusy));
      end
    end
  end

  // pseudo-random line data
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txData = lfsr[0]; directIn = lfsr[3]; matrixOut6 = lfsr[7]; matrixOut7 = lfsr[11];
    end
  end

  task automatic setAddr(bit init, int slot);
    @(negedge clk); addrWr = 1'b1; addrIn = {init, 5'(slot)};
    @(negedge clk); addrWr = 1'b0;
  endtask

  task automatic setData(logic [15:0] v);
    @(negedge clk); dataWr = 1'b1; dataIn = v;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); memWr = 1'b1;
    @(negedge clk); memWr = 1'b0;
  endtask

  task automatic softReset();
    @(negedge clk); swReset = 1'b1;
    @(negedge clk); swReset = 1'b0;
  endtask

  task automatic runFrame(output int txc, output int rxc, output int advc, output int s5c);
    txc = 0; rxc = 0; advc = 0; s5c = 0;
    @(negedge clk); frameSync = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      #(QTR);
      if (i == 0) frameSync = 1'b0;
      txc += int'(txEn);
      rxc += int'(rxEn);
      advc += int'(txAdvance);
      if (txEn && chanId == 5'd9) s5c++;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    done = 1'b1;
    finishRun();
  end

  initial begin
    int tx, rx, adv, s5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", "initBusy after reset", int'(initBusy), 1);
    chk("R1", "txEn before sync", int'(txEn), 0);
    chk("R1", "rdData after reset", int'(rdData), 0);

    repeat (40) @(negedge clk);
    setAddr(1'b0, 13); #1;
    chk("R4", "fill stopped", int'(initBusy), 0);
    chk("R4", "filled channel = slot", int'(rdData), 16'h000D);

    setData(16'hFFE0);
    softReset(); #1;
    chk("R11", "busy after swReset", int'(initBusy), 1);
    repeat (40) @(negedge clk);
    setAddr(1'b0, 4); #1;
    chk("R11", "data cleared before refill", int'(rdData), 16'h0004);

    setAddr(1'b0, 5); setData(16'hF629); commit(); #1;
    chk("R2", "slot 5 readback", int'(rdData), 16'hF629);
    setAddr(1'b0, 7); setData(16'h1FFE); commit(); #1;
    chk("R2", "slot 7 readback", int'(rdData), 16'h1FFE);
    setAddr(1'b0, 10); setData(16'h8023); commit(); #1;
    chk("R2", "slot 10 readback", int'(rdData), 16'h8023);

    setAddr(1'b0, 20); setData(16'h0155); commit();
    setData(16'h0003);
    setAddr(1'b1, 20);
    commit();
    setAddr(1'b0, 20); #1;
    chk("R3", "commit while busy ignored", int'(rdData), 16'h0155);
    setAddr(1'b0, 5); #1;
    chk("R3", "slot 5 untouched", int'(rdData), 16'hF629);

    runFrame(tx, rx, adv, s5);
    chk("R6", "frame1 txEn count", tx, 15);
    chk("R6", "slot5 bits frame1", s5, 4);
    chk("R8", "frame1 rxEn count", rx, 15);
    chk("R8", "frame1 txAdvance count", adv, 15);
    runFrame(tx, rx, adv, s5);
    chk("R8", "frame2 txEn repeat count", tx, 15);
    chk("R8", "slot5 bits repeated frame2", s5, 4);
    chk("R8", "frame2 rxEn count", rx, 11);
    chk("R7", "frame2 txAdvance count", adv, 11);
    contentionMode = 1'b1;
    runFrame(tx, rx, adv, s5);
    chk("R8", "frame3 rxEn count", rx, 15);
    chk("R10", "echoMask in contention mode", int'(echoMask), 0);
    contentionMode = 1'b0;
    runFrame(tx, rx, adv, s5);
    chk("R7", "frame4 rxEn count", rx, 11);

    done = 1'b1;
    finishRun();
  end
endmodule